// File: doc/BRIEF.md
# Four-Channel DMA Bus Arbiter

This block decides which of four DMA channels drives a shared external bus, and when the bus may pass from one channel to another. Each channel presents a request line, a two-bit transfer mode and an end-of-block marker. The arbiter answers with a one-hot channel grant, a flag that says a channel owns the bus, and a grant for another bus master that shares the same bus. Each completed bus cycle is reported to the arbiter as a one-clock transfer-done pulse.

Priority is fixed, and the lowest channel index wins. A channel in cycle-steal mode gives up the bus after every transfer. A channel in burst or block mode keeps the bus until its end-of-block marker arrives with a transfer-done pulse. Every time a channel gives up the bus, one handoff cycle follows. In that cycle no channel holds a grant, and the other master is granted if it is asking. The next channel is then chosen from the requests seen in the handoff cycle, and the channel that has just released the bus is left out of that choice.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While the synchronous active-high reset is applied, and in the first cycle after it, no channel grant, no bus ownership and no external grant is asserted.
- R2: When the bus is idle, the lowest-indexed requesting channel is granted in the cycle after its request is sampled, and `bus_own` rises in the same cycle.
- R3: `ch_gnt` is all-zero or one-hot at all times, and `ext_gnt` is never high in a cycle where any bit of `ch_gnt` is high.
- R4: Mode field of channel i is `ch_mode[2i+1:2i]`, and value 0 means cycle-steal. A granted cycle-steal channel releases the bus on the edge that samples `xfer_done` high.
- R5: Mode values 1 (burst), 2 (block) and 3 (treated as block) keep the grant on the current channel through any `xfer_done` pulse for which that channel's `ch_last` bit is low. A pulse with `ch_last` high releases the bus.
- R6: After every release there is exactly one handoff cycle with `ch_gnt` zero and `bus_own` low. In that cycle `ext_gnt` equals `ext_req`.
- R7: Leaving the handoff cycle, the arbiter grants the lowest-indexed requester other than the channel that released. If only that channel still requests, it is granted again. If no channel requests, the bus goes idle.
- R8: Requests are not latched. A request that is low in the cycle where selection is made is not granted, even if it was high earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_req | input | 4 | Per-channel transfer request |
| ch_mode | input | 8 | Two-bit mode per channel (0 steal, 1 burst, 2/3 block) |
| ch_last | input | 4 | Per-channel end-of-block marker, read with `xfer_done` |
| xfer_done | input | 1 | One-clock pulse at the end of each bus cycle |
| ext_req | input | 1 | Bus request from the other master |
| ch_gnt | output | 4 | One-hot channel grant |
| bus_own | output | 1 | A DMA channel owns the bus |
| ext_gnt | output | 1 | Grant to the other master during a handoff |

## Verification
Directed patterns cover four cases. Simultaneous requests from idle show whether priority is ordered correctly. Steal-mode chains with the winner still requesting show whether the releasing channel is left out and whether a lone requester can regain the bus. Burst and block runs with `ch_last` held low, then raised, show whether a switch is refused inside a run and taken at its end. A request dropped before the handoff cycle shows whether past requests are latched. Seeded random traffic then mixes modes, markers, done pulses and external requests, and a bench-side cycle model compares grants, ownership and the external grant every cycle.

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int NCH = 4,
  parameter int MW  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   ch_req,
  input  logic [NCH*MW-1:0] ch_mode,
  input  logic [NCH-1:0]   ch_last,
  input  logic             xfer_done,
  input  logic             ext_req,
  output logic [NCH-1:0]   ch_gnt,
  output logic             bus_own,
  output logic             ext_gnt
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} st_t;
  st_t st;
  logic [IW-1:0]  cur;
  logic [NCH-1:0] cur_hot, others, cand;
  logic [MW-1:0]  cur_mode;
  logic           rel, found;
  logic [IW-1:0]  pick;

  assign cur_hot  = NCH'(1) << cur;
  assign cur_mode = ch_mode[cur*MW +: MW];
  assign rel      = (st == S_RUN) && xfer_done && (cur_mode == '0 || ch_last[cur]);
  assign others   = ch_req & ~cur_hot;
  assign cand     = (st == S_GAP && others != '0) ? others : ch_req;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NCH-1; i >= 0; i--)
      if (cand[i]) begin
        pick  = IW'(i);
        found = 1'b1;
      end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_IDLE;
      cur <= '0;
    end else begin
      case (st)
        S_IDLE: if (found) begin st <= S_RUN; cur <= pick; end
        S_RUN:  if (rel) st <= S_GAP;
        default: begin
          if (found) begin st <= S_RUN; cur <= pick; end
          else st <= S_IDLE;
        end
      endcase
    end
  end

  assign bus_own = (st == S_RUN);
  assign ch_gnt  = bus_own ? cur_hot : '0;
  assign ext_gnt = (st == S_GAP) && ext_req;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ch_gnt == '0 && !bus_own && !ext_gnt));
  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(ch_gnt));
  // R3
  grant_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(ext_gnt && ch_gnt != '0));
  // R4
  steal_release_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_own && xfer_done && cur_mode == '0) |=> !bus_own);
  // R5
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_own && cur_mode != '0 && !(xfer_done && ch_last[cur])) |=> $stable(ch_gnt) && bus_own);
  // R6
  handoff_ext_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_own) |-> (ext_gnt == ext_req && ch_gnt == '0));
  // R7
  exclude_prev_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_GAP && others != '0) |=> (ch_gnt & $past(cur_hot)) == '0);
endmodule

// File: tb/dma_bus_arbiter_bench.sv
module dma_bus_arbiter_bench;
  logic clk = 0, rst = 1;
  logic [3:0] ch_req = 0, ch_last = 0;
  logic [7:0] ch_mode = 0;
  logic xfer_done = 0, ext_req = 0;
  logic [3:0] ch_gnt;
  logic bus_own, ext_gnt;
  int checks = 0, fails = 0, cyc = 0;
  int m_st = 0, m_cur = 0;

  always #2 clk = ~clk;

  dma_bus_arbiter u_dma_bus_arbiter (.clk, .rst, .ch_req, .ch_mode, .ch_last,
    .xfer_done, .ext_req, .ch_gnt, .bus_own, .ext_gnt);

  function automatic int lowest(input logic [3:0] m);
    for (int i = 0; i < 4; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic model_step();
    int p;
    if (rst) begin m_st = 0; m_cur = 0; return; end
    case (m_st)
      0: begin p = lowest(ch_req); if (p >= 0) begin m_st = 1; m_cur = p; end end
      1: if (xfer_done && (ch_mode[2*m_cur +: 2] == 0 || ch_last[m_cur])) m_st = 2;
      default: begin
        p = lowest(ch_req & ~(4'b1 << m_cur));
        if (p < 0) p = lowest(ch_req);
        if (p >= 0) begin m_st = 1; m_cur = p; end else m_st = 0;
      end
    endcase
  endtask

  task automatic cyc_run(input string tag, input logic [3:0] rq, input logic [7:0] md,
                         input logic [3:0] lst, input logic dn, input logic er);
    ch_req = rq; ch_mode = md; ch_last = lst; xfer_done = dn; ext_req = er;
    @(posedge clk);
    model_step();
    @(negedge clk);
    cyc++;
    chk(tag, ch_gnt, (m_st == 1) ? (4'b1 << m_cur) : 4'b0);
    chk(tag, bus_own, m_st == 1);
    chk(tag, ext_gnt, m_st == 2 && ext_req);
    chk("R3", $countones(ch_gnt) <= 1 && !(ext_gnt && ch_gnt != 0), 1);
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1;
    cyc_run("R1", 4'hF, 0, 0, 1, 1);
    cyc_run("R1", 4'hF, 0, 0, 1, 1);
    chk("R1", {ch_gnt, bus_own, ext_gnt}, 0);
    rst = 0;
    // R1: first cycle after reset, with no request present
    cyc_run("R1", 0, 0, 0, 0, 1);
    chk("R1", {ch_gnt, bus_own, ext_gnt}, 0);
    // R2: simultaneous requests from idle
    cyc_run("R2", 4'b1110, 0, 0, 0, 0);
    chk("R2", ch_gnt, 4'b0010);
    // R4 and R7: steal mode, ch1 keeps requesting but is left out
    cyc_run("R4", 4'b1110, 0, 0, 1, 0);
    chk("R4", bus_own, 0);
    cyc_run("R7", 4'b1110, 0, 0, 0, 0);
    chk("R7", ch_gnt, 4'b0100);
    // R6: handoff with the external master requesting
    cyc_run("R6", 4'b0100, 0, 0, 1, 1);
    chk("R6", ext_gnt, 1);
    // R7: lone requester regains the bus
    cyc_run("R7", 4'b0100, 0, 0, 0, 1);
    chk("R7", ch_gnt, 4'b0100);
    // R5: burst on ch2 holds through done pulses without the marker
    for (int i = 0; i < 4; i++) begin
      cyc_run("R5", 4'b0101, 8'h10, 0, 1, 1);
      chk("R5", ch_gnt, 4'b0100);
    end
    cyc_run("R5", 4'b0101, 8'h10, 4'b0100, 1, 0);
    chk("R5", bus_own, 0);
    // R6: idle handoff cycle, then ch0
    cyc_run("R6", 4'b0101, 8'h10, 0, 0, 0);
    chk("R6", ch_gnt, 4'b0001);
    // R5: block mode on ch0
    cyc_run("R5", 4'b1001, 8'h02, 0, 1, 0);
    chk("R5", ch_gnt, 4'b0001);
    cyc_run("R5", 4'b1011, 8'h02, 4'b0001, 1, 0);
    chk("R5", bus_own, 0);
    // R8: ch1 dropped before the handoff, ch3 remains
    cyc_run("R8", 4'b1000, 0, 0, 0, 0);
    chk("R8", ch_gnt, 4'b1000);
    cyc_run("R8", 4'b0000, 0, 0, 1, 0);
    cyc_run("R8", 4'b0000, 0, 0, 0, 0);
    chk("R8", {ch_gnt, bus_own}, 0);
    // R7: seeded random traffic
    for (int i = 0; i < 800; i++)
      cyc_run("R7", 4'($urandom), 8'($urandom), 4'($urandom),
              1'($urandom_range(0, 2) != 0), 1'($urandom));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule